// File: doc/BRIEF.md
# Cached pixel read unit

This block serves copy-pixel commands that wait in a show-ahead command FIFO. Each command carries a 20-bit word address, a bits-per-pixel code and a sub-word bit position. For each command the block finds the memory word that holds the packed pixel and picks out the pixel's field. It returns the colour together with the code and the position it used.

The block keeps a single cached word with an address tag and a valid flag. When a command names the cached address, the result comes from the cached word and no memory traffic occurs. When it names another address, the block takes the command and pulses a read request. It then stops pulling commands from the FIFO until the memory controller returns the word with a data-ready pulse. A flush input drops the cached word after any write that may have changed it.

Top module: `cached_pixel_reader`

## Requirements
- R1: While reset is held and right after it, `rd_req`, `pix_valid` and `cmd_shift` are 0. `pix_colour`, `pix_bpp` and `pix_pos` are 0, and the cache holds nothing valid.
- R2: A command whose address equals the cached address, while the cache is valid and `flush` is low, causes no read request. `pix_valid` rises on the clock after the command is taken. The result carries the new code and position, with the colour taken from the cached word.
- R3: Any other command is taken from the FIFO and starts a read. On the next clock, `rd_req` is high for exactly one cycle and `rd_addr` holds the command's address (bits [27:8] of `cmd_data`).
- R4: From the clock that raises `rd_req` until data-ready, `cmd_shift` stays 0 whatever `cmd_empty` does.
- R5: `rd_ready` while waiting stores `rd_data` and its address as the cached word, and marks the cache valid. `pix_valid` rises on the next clock, with the colour taken from `rd_data`.
- R6: In the cycle after data-ready, `cmd_shift` is 1 again if the FIFO is not empty.
- R7: `cmd_data` packs {address[27:8], code[7:4], position[3:0]}. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel; code 4 and above select 16. The colour is word bits [position+width-1 : position]. Bits above bit 15 read as zero, and the colour is zero-extended to 16 bits.
- R8: `pix_valid` pulses once for each command taken, whether it hit or missed, and at no other time.
- R9: `flush` high clears the valid flag, so the next command always misses. If `flush` comes while a read is outstanding, the word that returns is stored but left invalid.
- R10: `rd_ready` arriving while no read is outstanding changes neither the outputs nor the cached word.
- R11: `cmd_shift` is never high while `cmd_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate the cached word |
| cmd_data | input | 28 | Head of the command FIFO: {address, code, position} |
| cmd_empty | input | 1 | Command FIFO empty |
| cmd_shift | output | 1 | Pops the FIFO head at this clock edge |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 20 | Word address of the read |
| rd_data | input | 16 | Word returned by memory |
| rd_ready | input | 1 | One-cycle pulse: `rd_data` is valid |
| pix_valid | output | 1 | One-cycle result pulse |
| pix_colour | output | 16 | Extracted pixel colour |
| pix_bpp | output | 4 | Bits-per-pixel code of the result |
| pix_pos | output | 4 | Sub-word bit position of the result |

## Verification
The bench runs runs of commands that repeat, change and interleave addresses, with both short and long memory latency. A design that took a command while a read was outstanding would produce results out of order or miss a request. A design that compared the tag without the valid flag would skip the first read after reset or after a flush. Colour fields are placed at the top of the word, so a design that wrapped them around or dropped the mask for codes above 4 would return wrong colours. A stray data-ready while idle and a flush during an outstanding read are both covered. A design that stored the stray word, or kept the refilled word valid after such a flush, would return a stale colour on the next command to that address.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

  typedef enum logic {
    CPR_IDLE = 1'b0,
    CPR_WAIT = 1'b1
  } cpr_state_e;

  // Pixel width selected by a code: 2**code, capped at 2**max_log.
  function automatic int unsigned code_width(input int unsigned code,
                                             input int unsigned max_log);
    int unsigned lg;
    lg = (code > max_log) ? max_log : code;
    return 32'd1 << lg;
  endfunction

endpackage

// File: rtl/cpr_tag_match.sv
module cpr_tag_match #(
  parameter int ADDR_W = 20
) (
  input  logic              tag_valid,
  input  logic [ADDR_W-1:0] tag_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              kill,
  output logic              hit
);
  assign hit = tag_valid && (tag_addr == probe_addr) && !kill;
endmodule

// File: rtl/cpr_field_extract.sv
module cpr_field_extract #(
  parameter int DATA_W = 16,
  parameter int BPP_W  = 4,
  parameter int POS_W  = 4
) (
  input  logic [DATA_W-1:0] word,
  input  logic [BPP_W-1:0]  code,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] field
);
  localparam int unsigned MAX_LOG = $clog2(DATA_W);

  int unsigned        width;
  logic [DATA_W-1:0]  shifted;
  logic [DATA_W-1:0]  mask;

  always_comb begin
    width   = cpr_pkg::code_width(32'(code), MAX_LOG);
    shifted = word >> pos;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (32'(g) < width);
  end

  assign field = shifted & mask;
endmodule

// File: rtl/cached_pixel_reader.sv
module cached_pixel_reader #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BPP_W  = 4,
  parameter int POS_W  = $clog2(DATA_W),
  localparam int CMD_W = ADDR_W + BPP_W + POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_empty,
  output logic              cmd_shift,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_colour,
  output logic [BPP_W-1:0]  pix_bpp,
  output logic [POS_W-1:0]  pix_pos
);
  import cpr_pkg::*;

  cpr_state_e        state;
  logic              cache_valid;
  logic [ADDR_W-1:0] cache_addr;
  logic [DATA_W-1:0] cache_word;
  logic [ADDR_W-1:0] pend_addr;
  logic [BPP_W-1:0]  pend_bpp;
  logic [POS_W-1:0]  pend_pos;
  logic              flush_seen;

  logic              rd_req_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              pix_valid_q;
  logic [DATA_W-1:0] pix_colour_q;
  logic [BPP_W-1:0]  pix_bpp_q;
  logic [POS_W-1:0]  pix_pos_q;

  // Command head fields
  logic [ADDR_W-1:0] hd_addr;
  logic [BPP_W-1:0]  hd_bpp;
  logic [POS_W-1:0]  hd_pos;
  assign {hd_addr, hd_bpp, hd_pos} = cmd_data;

  // Named internal events, used by the checker
  logic hit;
  logic waiting;
  logic hit_evt;
  logic miss_evt;
  logic fill_evt;

  logic [DATA_W-1:0] hit_field;
  logic [DATA_W-1:0] fill_field;

  cpr_tag_match #(.ADDR_W(ADDR_W)) u_tag (
    .tag_valid  (cache_valid),
    .tag_addr   (cache_addr),
    .probe_addr (hd_addr),
    .kill       (flush),
    .hit        (hit)
  );

  cpr_field_extract #(.DATA_W(DATA_W), .BPP_W(BPP_W), .POS_W(POS_W)) u_hit_ext (
    .word  (cache_word),
    .code  (hd_bpp),
    .pos   (hd_pos),
    .field (hit_field)
  );

  cpr_field_extract #(.DATA_W(DATA_W), .BPP_W(BPP_W), .POS_W(POS_W)) u_fill_ext (
    .word  (rd_data),
    .code  (pend_bpp),
    .pos   (pend_pos),
    .field (fill_field)
  );

  assign waiting   = (state == CPR_WAIT);
  assign cmd_shift = rst_n && !waiting && !cmd_empty;
  assign hit_evt   = cmd_shift && hit;
  assign miss_evt  = cmd_shift && !hit;
  assign fill_evt  = waiting && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= CPR_IDLE;
      cache_valid  <= 1'b0;
      cache_addr   <= '0;
      cache_word   <= '0;
      pend_addr    <= '0;
      pend_bpp     <= '0;
      pend_pos     <= '0;
      flush_seen   <= 1'b0;
      rd_req_q     <= 1'b0;
      rd_addr_q    <= '0;
      pix_valid_q  <= 1'b0;
      pix_colour_q <= '0;
      pix_bpp_q    <= '0;
      pix_pos_q    <= '0;
    end else begin
      rd_req_q    <= 1'b0;
      pix_valid_q <= 1'b0;
      if (flush) begin
        cache_valid <= 1'b0;
        if (waiting) flush_seen <= 1'b1;
      end
      if (hit_evt) begin
        pix_colour_q <= hit_field;
        pix_bpp_q    <= hd_bpp;
        pix_pos_q    <= hd_pos;
        pix_valid_q  <= 1'b1;
      end else if (miss_evt) begin
        pend_addr   <= hd_addr;
        pend_bpp    <= hd_bpp;
        pend_pos    <= hd_pos;
        rd_req_q    <= 1'b1;
        rd_addr_q   <= hd_addr;
        cache_valid <= 1'b0;
        flush_seen  <= 1'b0;
        state       <= CPR_WAIT;
      end else if (fill_evt) begin
        cache_word   <= rd_data;
        cache_addr   <= pend_addr;
        cache_valid  <= !flush_seen && !flush;
        pix_colour_q <= fill_field;
        pix_bpp_q    <= pend_bpp;
        pix_pos_q    <= pend_pos;
        pix_valid_q  <= 1'b1;
        state        <= CPR_IDLE;
      end
    end
  end

  assign rd_req     = rd_req_q;
  assign rd_addr    = rd_addr_q;
  assign pix_valid  = pix_valid_q;
  assign pix_colour = pix_colour_q;
  assign pix_bpp    = pix_bpp_q;
  assign pix_pos    = pix_pos_q;
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_empty,
  input logic cmd_shift,
  input logic rd_req,
  input logic rd_ready,
  input logic pix_valid,
  input logic waiting,
  input logic hit_evt,
  input logic miss_evt,
  input logic fill_evt
);
  assert_shift_not_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_shift |-> !cmd_empty);

  assert_miss_requests_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (rd_req && waiting));

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_stall_while_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !cmd_shift);

  assert_hit_no_memory_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (pix_valid && !rd_req));

  assert_fill_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (pix_valid && !waiting));

  assert_result_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ($past(hit_evt) || $past(fill_evt)));

  assert_stray_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !waiting && !cmd_shift) |=> !pix_valid);
endmodule

bind cached_pixel_reader cpr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_empty (cmd_empty),
  .cmd_shift (cmd_shift),
  .rd_req    (rd_req),
  .rd_ready  (rd_ready),
  .pix_valid (pix_valid),
  .waiting   (waiting),
  .hit_evt   (hit_evt),
  .miss_evt  (miss_evt),
  .fill_evt  (fill_evt)
);

// File: tb/cached_pixel_reader_tb.sv
module cached_pixel_reader_tb;
  typedef struct packed {
    logic        fl;
    logic [19:0] a;
    logic [3:0]  b;
    logic [3:0]  p;
  } item_t;

  typedef struct packed {
    logic [15:0] c;
    logic [3:0]  b;
    logic [3:0]  p;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [27:0] cmd_data = '0;
  logic        cmd_empty = 1'b1;
  logic        cmd_shift;
  logic        rd_req;
  logic [19:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic        rd_ready = 1'b0;
  logic        pix_valid;
  logic [15:0] pix_colour;
  logic [3:0]  pix_bpp;
  logic [3:0]  pix_pos;

  always #2 clk = ~clk;

  cached_pixel_reader u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmd_data(cmd_data),
    .cmd_empty(cmd_empty), .cmd_shift(cmd_shift), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .pix_valid(pix_valid), .pix_colour(pix_colour), .pix_bpp(pix_bpp),
    .pix_pos(pix_pos)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit running = 0;

  item_t       cmdq[$];
  exp_t        expq[$];
  logic [19:0] addrq[$];

  bit          m_valid = 0;
  logic [19:0] m_addr = '0;
  int          exp_misses = 0;
  int          seen_misses = 0;
  int          latency = 1;
  bit          outstanding = 0;
  int          cnt = 0;
  logic [19:0] req_addr = '0;
  bit          pop_pend = 0;
  bit          ready_prev = 0;
  bit          flush_wait_req = 0;
  bit          spur_req = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return {a[3:0] ^ 4'h9, a[7:4] + 4'h5, a[11:8] ^ a[19:16], a[15:12] + 4'hC};
  endfunction

  // Field by bit loop: width 2**min(code,4), positions beyond bit 15 read 0.
  function automatic logic [15:0] pick(input logic [15:0] w, input logic [3:0] code,
                                       input logic [3:0] pos);
    int wd;
    logic [15:0] r;
    wd = (code >= 4) ? 16 : (1 << code);
    r = '0;
    for (int i = 0; i < wd; i++) begin
      if (int'(pos) + i < 16) r[i] = w[int'(pos) + i];
    end
    return r;
  endfunction

  // Driver: queues a command and its expected result.
  task automatic push_cmd(input logic [19:0] a, input logic [3:0] b,
                          input logic [3:0] p, input bit fl);
    item_t it;
    exp_t  e;
    bit    h;
    @(posedge clk);
    h = m_valid && (a == m_addr) && !fl;
    if (!h) begin
      exp_misses++;
      addrq.push_back(a);
      m_addr  = a;
      m_valid = 1;
    end
    it.fl = fl; it.a = a; it.b = b; it.p = p;
    e.c = pick(mem_word(a), b, p); e.b = b; e.p = p;
    cmdq.push_back(it);
    expq.push_back(e);
  endtask

  task automatic drain(input string tag);
    int guard;
    guard = 0;
    while ((cmdq.size() != 0 || expq.size() != 0 || outstanding) && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    repeat (3) @(posedge clk);
    check(expq.size() == 0, {tag, " drained"}, expq.size(), 0);
    check(seen_misses == exp_misses, {tag, " read count"}, seen_misses, exp_misses);
  endtask

  // FIFO and memory model
  always @(negedge clk) begin
    if (running) begin
      if (pop_pend && cmdq.size() != 0) void'(cmdq.pop_front());
      rd_ready = 1'b0;
      flush = 1'b0;
      if (outstanding) begin
        if (cnt == 0) begin
          rd_ready = 1'b1;
          rd_data = mem_word(req_addr);
          outstanding = 0;
        end else cnt--;
      end
      if (rd_req) begin
        seen_misses++;
        if (addrq.size() != 0) begin
          logic [19:0] ea;
          ea = addrq.pop_front();
          check(rd_addr == ea, "R3 read address", rd_addr, ea);
        end else check(0, "R3 unexpected read", rd_addr, 0);
        outstanding = 1;
        cnt = latency;
        req_addr = rd_addr;
      end
      if (!outstanding && !rd_ready && spur_req && cmdq.size() == 0) begin
        rd_ready = 1'b1;
        rd_data = 16'hFFFF;
        spur_req = 0;
      end
      if (outstanding && flush_wait_req) begin
        flush = 1'b1;
        flush_wait_req = 0;
      end else if (!outstanding && !rd_ready && cmdq.size() != 0 && cmdq[0].fl) begin
        flush = 1'b1;
      end
      cmd_empty = (cmdq.size() == 0);
      cmd_data  = (cmdq.size() != 0) ? {cmdq[0].a, cmdq[0].b, cmdq[0].p} : '0;
      #1;
      if (rd_req) check(cmd_shift == 1'b0, "R4 stall while read outstanding", cmd_shift, 0);
      if (ready_prev)
        check(cmd_shift == (cmdq.size() != 0), "R6 shift resumes", cmd_shift, cmdq.size() != 0);
      if (cmd_empty) check(cmd_shift == 1'b0, "R11 no shift when empty", cmd_shift, 0);
      ready_prev = rd_ready && !spur_req && (rd_data != 16'hFFFF || 1'b1) && !outstanding
                   && rd_ready;
      pop_pend = cmd_shift;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (running && pix_valid) begin
      if (expq.size() == 0) begin
        check(0, "R8 R10 unexpected result", pix_colour, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(pix_colour == e.c, "R7 colour", pix_colour, e.c);
        check(pix_bpp == e.b && pix_pos == e.p, "R2 R5 fields",
              {pix_bpp, pix_pos}, {e.b, e.p});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_req == 0 && pix_valid == 0 && cmd_shift == 0, "R1 reset controls",
          {rd_req, pix_valid, cmd_shift}, 0);
    check(pix_colour == 0 && pix_bpp == 0 && pix_pos == 0, "R1 reset results",
          {pix_colour, pix_bpp, pix_pos}, 0);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    check(rd_req == 0 && pix_valid == 0, "R1 after reset", {rd_req, pix_valid}, 0);

    // R2 R3 R5: miss then hits on the same word
    latency = 1;
    push_cmd(20'h12345, 4'd3, 4'd0, 0);
    push_cmd(20'h12345, 4'd3, 4'd8, 0);
    push_cmd(20'h12345, 4'd0, 4'd15, 0);
    push_cmd(20'h12345, 4'd2, 4'd4, 0);
    drain("R2 hits");

    // R4 R6: alternating addresses queued behind a slow read
    latency = 4;
    push_cmd(20'hABCDE, 4'd1, 4'd6, 0);
    push_cmd(20'h00001, 4'd4, 4'd0, 0);
    push_cmd(20'h00001, 4'd3, 4'd8, 0);
    push_cmd(20'hFFFFF, 4'd2, 4'd12, 0);
    push_cmd(20'hABCDE, 4'd1, 4'd2, 0);
    drain("R4 interleave");

    // R7: every code and top-of-word positions
    latency = 2;
    for (int c = 0; c < 16; c++) push_cmd(20'h5A5A5, 4'(c), 4'(c), 0);
    push_cmd(20'h5A5A5, 4'd3, 4'd12, 0);
    push_cmd(20'h5A5A5, 4'd4, 4'd9, 0);
    drain("R7 codes");

    // R9: flush alongside a command to the cached word
    push_cmd(20'h5A5A5, 4'd3, 4'd0, 1);
    push_cmd(20'h5A5A5, 4'd3, 4'd8, 0);
    drain("R9 flush with command");

    // R9: flush while a read is outstanding
    latency = 3;
    push_cmd(20'h33333, 4'd3, 4'd0, 0);
    flush_wait_req = 1;
    m_valid = 0;
    push_cmd(20'h33333, 4'd3, 4'd8, 0);
    drain("R9 flush in wait");

    // R10: stray data-ready while idle, then a hit must use the old word
    latency = 1;
    push_cmd(20'h0BEEF, 4'd4, 4'd0, 0);
    drain("R10 setup");
    spur_req = 1;
    repeat (4) @(posedge clk);
    check(spur_req == 0, "R10 stray ready issued", spur_req, 0);
    push_cmd(20'h0BEEF, 4'd4, 4'd0, 0);
    drain("R10 stray ready");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule